// File: doc/BRIEF.md
# Serial Flash Status and Configuration Register Controller

This block keeps the status register and configuration register of a serial NOR flash front-end. Each register has a volatile and a non-volatile copy. It sits behind a SPI command decoder that has already recognised each command. The decoder hands it one-cycle strobes for these commands:

- set write enable
- write registers, with the received data bytes and a flag for a second byte
- clear status
- start program or start erase
- write to the one-time-programmable (OTP) area

The flash array returns a completion strobe with fail and protected flags.

The block keeps these flags:

- write enable latch
- write-in-progress (busy)
- latched program error and latched erase error
- freeze lock over the protection fields

The non-volatile copies are plain flops that load parameter defaults at reset. The volatile copies load from the non-volatile defaults at reset.

Status byte layout:

| Bit | Meaning |
| --- | --- |
| 0 | write-in-progress |
| 1 | write enable latch |
| 4:2 | block-protect field |
| 5 | erase error |
| 6 | program error |
| 7 | status-write-disable bit, which is stored only |

Configuration byte layout:

| Bit | Meaning |
| --- | --- |
| 0 | freeze (volatile only) |
| 1 | quad enable |
| 2 | protection-location bit |
| 3 | protection-volatility bit |
| 5 | protection-location bit |
| 4, 6, 7 | general bits |

Configuration bits 2, 3 and 5 exist only in the non-volatile copy. The volatile view mirrors them.

The decoder issues at most one command strobe per cycle. Every accepted command shows on the outputs one clock edge after its strobe.

Top module: `sfRegCtrl`

## Requirements
- R1: After reset the outputs are as follows. The write enable latch, write-in-progress, both error bits, the freeze bit, busy and otpWrGo are 0. sr1Nv equals Sr1NvInit masked to bits 7 and 4:2. sr1V carries those same bits. cr1Nv equals Cr1NvInit with bit 0 cleared. cr1V equals cr1Nv.
- R2: A write-enable strobe while not busy sets sr1V bit 1. While busy the strobe is ignored.
- R3: A program or erase start is accepted only when the write enable latch is set and the block is not busy. It then sets sr1V bit 0 and busy, and clears sr1V bit 1. Without the latch the start has no effect.
- R4: A completion without fail or protected flags ends the operation. It clears sr1V bit 0 and busy and leaves both error bits at 0.
- R5: A program completion with the fail flag or the protected flag sets sr1V bit 6 and keeps sr1V bit 0 and busy at 1. These stay set until clear-status.
- R6: An erase completion with the fail flag or the protected flag sets sr1V bit 5 and keeps sr1V bit 0 and busy at 1. These stay set until clear-status.
- R7: Clear-status while an error is latched clears bits 6, 5, 1 and 0 of sr1V and drops busy. While an operation is still running without error, clear-status is ignored.
- R8: A register write is accepted only when the write enable latch is set and the block is not busy. It clears the latch. Otherwise no register changes.
- R9: A register write with a single data byte updates only status bits 7 and 4:2 from wrrByte0. Both configuration copies keep their value, whatever wrrByte1 holds.
- R10: A register write with two bytes also writes the configuration register from wrrByte1. With wrrVolatile=1 only the volatile copies change, meaning status bits 7 and 4:2 and configuration bits 1, 4, 6 and 7. With wrrVolatile=0 both the non-volatile copies and the volatile copies are written.
- R11: While the freeze bit (cr1V bit 0) is 1, register writes cannot change status bits 4:2 in either copy or cr1Nv bits 2, 3 and 5. The other writable bits still update.
- R12: The freeze bit is set by a two-byte register write with wrrByte1 bit 0 at 1. Only reset clears it.
- R13: An OTP write request while the latch is set, the block is not busy and the freeze bit is 0 gives a one-cycle otpWrGo pulse and clears the latch. Otherwise no pulse follows.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWren | input | 1 | Write-enable command strobe |
| cmdWrr | input | 1 | Write-registers command strobe |
| wrrTwoBytes | input | 1 | Write-registers carried a second data byte |
| wrrVolatile | input | 1 | Write-registers targets volatile copies only |
| wrrByte0 | input | 8 | First data byte (status) |
| wrrByte1 | input | 8 | Second data byte (configuration) |
| cmdClsr | input | 1 | Clear-status command strobe |
| cmdProg | input | 1 | Program start command strobe |
| cmdErase | input | 1 | Erase start command strobe |
| opDone | input | 1 | Array operation completed |
| opFail | input | 1 | Completed operation failed |
| opProtected | input | 1 | Completed operation targeted a protected sector |
| cmdOtpWr | input | 1 | OTP write request strobe |
| sr1V | output | 8 | Volatile status register |
| sr1Nv | output | 8 | Non-volatile status register |
| cr1V | output | 8 | Volatile configuration register |
| cr1Nv | output | 8 | Non-volatile configuration register |
| busy | output | 1 | Operation in progress or error pending |
| otpWrGo | output | 1 | One-cycle grant for an OTP write |

## Verification
A wrong write enable latch shows in sr1V bit 1 on the next cycle. It also shows as a register write or start that is accepted or refused against expectation. A control state that disagrees with the register flags shows as busy differing from sr1V bit 0 in the same cycle. A freeze or byte-count masking error shows in sr1Nv, cr1Nv or cr1V one cycle after the write strobe. Every output is compared against a bench model after every cycle, so such faults are reported at most one cycle after they arise.

// File: rtl/sfRegPkg.sv
package sfRegPkg;
  localparam int RegW = 8;
  // status bits software may write: 7 and 4:2
  localparam logic [RegW-1:0] Sr1WrMask   = 8'h9C;
  // block-protect field, locked by freeze
  localparam logic [RegW-1:0] Sr1BpMask   = 8'h1C;
  // configuration bits stored non-volatile: 7..1
  localparam logic [RegW-1:0] Cr1NvMask   = 8'hFE;
  // non-volatile configuration bits locked by freeze: 5, 3, 2
  localparam logic [RegW-1:0] Cr1LockMask = 8'h2C;
  // configuration bits with their own volatile copy: 7, 6, 4, 1
  localparam logic [RegW-1:0] Cr1VolMask  = 8'hD2;

  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic setWip;
    logic clrWip;
    logic setPErr;
    logic setEErr;
    logic clrErr;
    logic wrReg;
    logic otpGo;
  } regStrobes_t;

  typedef enum logic [1:0] {StIdle, StProg, StErase, StFault} ctrlState_e;
endpackage

// File: rtl/sfRegCtrlFsm.sv
module sfRegCtrlFsm
  import sfRegPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        cmdWren,
  input  logic        cmdWrr,
  input  logic        cmdClsr,
  input  logic        cmdProg,
  input  logic        cmdErase,
  input  logic        opDone,
  input  logic        opFail,
  input  logic        opProtected,
  input  logic        cmdOtpWr,
  input  logic        welIn,
  input  logic        freezeIn,
  output regStrobes_t strobes,
  output logic        busy
);
  ctrlState_e state, nextState;
  logic opBad;

  assign opBad = opFail | opProtected;

  always_comb begin
    strobes   = '0;
    nextState = state;
    unique case (state)
      StIdle: begin
        if (cmdWrr && welIn) begin
          strobes.wrReg  = 1'b1;
          strobes.clrWel = 1'b1;
        end else if (cmdProg && welIn) begin
          strobes.setWip = 1'b1;
          strobes.clrWel = 1'b1;
          nextState      = StProg;
        end else if (cmdErase && welIn) begin
          strobes.setWip = 1'b1;
          strobes.clrWel = 1'b1;
          nextState      = StErase;
        end else if (cmdOtpWr && welIn && !freezeIn) begin
          strobes.otpGo  = 1'b1;
          strobes.clrWel = 1'b1;
        end else if (cmdWren) begin
          strobes.setWel = 1'b1;
        end
      end
      StProg, StErase: begin
        if (opDone) begin
          if (opBad) begin
            strobes.setPErr = (state == StProg);
            strobes.setEErr = (state == StErase);
            nextState       = StFault;
          end else begin
            strobes.clrWip = 1'b1;
            nextState      = StIdle;
          end
        end
      end
      StFault: begin
        if (cmdClsr) begin
          strobes.clrErr = 1'b1;
          strobes.clrWip = 1'b1;
          strobes.clrWel = 1'b1;
          nextState      = StIdle;
        end
      end
      default: nextState = StIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= StIdle;
    else       state <= nextState;
  end

  assign busy = (state != StIdle);
endmodule

// File: rtl/sfRegDatapath.sv
module sfRegDatapath
  import sfRegPkg::*;
#(
  parameter logic [RegW-1:0] Sr1NvInit = '0,
  parameter logic [RegW-1:0] Cr1NvInit = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  regStrobes_t     strobes,
  input  logic            wrrTwoBytes,
  input  logic            wrrVolatile,
  input  logic [RegW-1:0] wrrByte0,
  input  logic [RegW-1:0] wrrByte1,
  output logic            welOut,
  output logic            freezeOut,
  output logic [RegW-1:0] sr1V,
  output logic [RegW-1:0] sr1Nv,
  output logic [RegW-1:0] cr1V,
  output logic [RegW-1:0] cr1Nv,
  output logic            otpWrGo
);
  logic [RegW-1:0] srNvReg, srVolReg, crNvReg, crVolReg;
  logic [RegW-1:0] srMask, crNvWrMask;
  logic wel, wip, pErr, eErr, freeze;

  assign srMask     = freeze ? (Sr1WrMask & ~Sr1BpMask) : Sr1WrMask;
  assign crNvWrMask = freeze ? (Cr1NvMask & ~Cr1LockMask) : Cr1NvMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srNvReg  <= Sr1NvInit & Sr1WrMask;
      srVolReg <= Sr1NvInit & Sr1WrMask;
      crNvReg  <= Cr1NvInit & Cr1NvMask;
      crVolReg <= Cr1NvInit & Cr1VolMask;
      freeze   <= 1'b0;
    end else if (strobes.wrReg) begin
      srVolReg <= (srVolReg & ~srMask) | (wrrByte0 & srMask);
      if (!wrrVolatile) srNvReg <= (srNvReg & ~srMask) | (wrrByte0 & srMask);
      if (wrrTwoBytes) begin
        crVolReg <= (crVolReg & ~Cr1VolMask) | (wrrByte1 & Cr1VolMask);
        freeze   <= freeze | wrrByte1[0];
        if (!wrrVolatile) crNvReg <= (crNvReg & ~crNvWrMask) | (wrrByte1 & crNvWrMask);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wel     <= 1'b0;
      wip     <= 1'b0;
      pErr    <= 1'b0;
      eErr    <= 1'b0;
      otpWrGo <= 1'b0;
    end else begin
      if (strobes.setWel)      wel <= 1'b1;
      else if (strobes.clrWel) wel <= 1'b0;
      if (strobes.setWip)      wip <= 1'b1;
      else if (strobes.clrWip) wip <= 1'b0;
      if (strobes.setPErr)     pErr <= 1'b1;
      else if (strobes.clrErr) pErr <= 1'b0;
      if (strobes.setEErr)     eErr <= 1'b1;
      else if (strobes.clrErr) eErr <= 1'b0;
      otpWrGo <= strobes.otpGo;
    end
  end

  assign welOut    = wel;
  assign freezeOut = freeze;
  assign sr1Nv     = srNvReg & Sr1WrMask;
  assign sr1V      = (srVolReg & Sr1WrMask) | {1'b0, pErr, eErr, 3'b000, wel, wip};
  assign cr1Nv     = crNvReg & Cr1NvMask;
  assign cr1V      = (crVolReg & Cr1VolMask) | (crNvReg & Cr1LockMask) | {{(RegW-1){1'b0}}, freeze};
endmodule

// File: rtl/sfRegCtrl.sv
module sfRegCtrl
  import sfRegPkg::*;
#(
  parameter logic [7:0] Sr1NvInit = 8'h00,
  parameter logic [7:0] Cr1NvInit = 8'h00
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdWren,
  input  logic       cmdWrr,
  input  logic       wrrTwoBytes,
  input  logic       wrrVolatile,
  input  logic [7:0] wrrByte0,
  input  logic [7:0] wrrByte1,
  input  logic       cmdClsr,
  input  logic       cmdProg,
  input  logic       cmdErase,
  input  logic       opDone,
  input  logic       opFail,
  input  logic       opProtected,
  input  logic       cmdOtpWr,
  output logic [7:0] sr1V,
  output logic [7:0] sr1Nv,
  output logic [7:0] cr1V,
  output logic [7:0] cr1Nv,
  output logic       busy,
  output logic       otpWrGo
);
  regStrobes_t strobes;
  logic wel, freeze;

  sfRegCtrlFsm i_ctrl (
    .clk(clk), .rstN(rstN), .cmdWren(cmdWren), .cmdWrr(cmdWrr), .cmdClsr(cmdClsr),
    .cmdProg(cmdProg), .cmdErase(cmdErase), .opDone(opDone), .opFail(opFail),
    .opProtected(opProtected), .cmdOtpWr(cmdOtpWr), .welIn(wel), .freezeIn(freeze),
    .strobes(strobes), .busy(busy)
  );

  sfRegDatapath #(.Sr1NvInit(Sr1NvInit), .Cr1NvInit(Cr1NvInit)) i_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .wrrTwoBytes(wrrTwoBytes),
    .wrrVolatile(wrrVolatile), .wrrByte0(wrrByte0), .wrrByte1(wrrByte1),
    .welOut(wel), .freezeOut(freeze), .sr1V(sr1V), .sr1Nv(sr1Nv), .cr1V(cr1V),
    .cr1Nv(cr1Nv), .otpWrGo(otpWrGo)
  );
endmodule

// File: rtl/sfRegCtrlChk.sv
module sfRegCtrlChk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdWrr,
  input logic       wrrTwoBytes,
  input logic       cmdClsr,
  input logic [7:0] sr1V,
  input logic [7:0] sr1Nv,
  input logic [7:0] cr1V,
  input logic [7:0] cr1Nv,
  input logic       busy,
  input logic       otpWrGo
);
  // R3
  busy_wip_agree_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy == sr1V[0]);
  // R3
  start_clears_wel_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> !sr1V[1]);
  // R5
  perr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sr1V[6] && !cmdClsr) |=> (sr1V[6] && sr1V[0]));
  // R6
  eerr_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sr1V[5] && !cmdClsr) |=> (sr1V[5] && sr1V[0]));
  // R8
  busy_blocks_wrr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWrr) |=> ($stable(sr1Nv) && $stable(cr1Nv) && $stable(cr1V) && $stable(sr1V[7])));
  // R9
  single_byte_cfg_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdWrr && !wrrTwoBytes) |=> ($stable(cr1V) && $stable(cr1Nv)));
  // R11
  freeze_lock_chk: assert property (@(posedge clk) disable iff (!rstN)
    cr1V[0] |=> ($stable(sr1V[4:2]) && $stable(sr1Nv[4:2]) && $stable(cr1Nv[5]) &&
                 $stable(cr1Nv[3:2])));
  // R12
  freeze_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    cr1V[0] |=> cr1V[0]);
  // R13
  otp_not_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    otpWrGo |-> !cr1V[0]);
endmodule

bind sfRegCtrl sfRegCtrlChk i_chk (
  .clk(clk), .rstN(rstN), .cmdWrr(cmdWrr), .wrrTwoBytes(wrrTwoBytes), .cmdClsr(cmdClsr),
  .sr1V(sr1V), .sr1Nv(sr1Nv), .cr1V(cr1V), .cr1Nv(cr1Nv), .busy(busy), .otpWrGo(otpWrGo)
);

// File: tb/test_sfRegCtrl.sv
module test_sfRegCtrl;
  localparam logic [7:0] SrInit = 8'h8C;
  localparam logic [7:0] CrInit = 8'h26;
  localparam int CNone = 0, CWren = 1, CWrr = 2, CProg = 3, CErase = 4,
                 CDone = 5, CClsr = 6, COtp = 7;

  logic clk = 1'b0, rstN = 1'b0;
  logic cmdWren = 0, cmdWrr = 0, wrrTwoBytes = 0, wrrVolatile = 0;
  logic [7:0] wrrByte0 = 0, wrrByte1 = 0;
  logic cmdClsr = 0, cmdProg = 0, cmdErase = 0, opDone = 0, opFail = 0, opProtected = 0, cmdOtpWr = 0;
  logic [7:0] sr1V, sr1Nv, cr1V, cr1Nv;
  logic busy, otpWrGo;

  int errors = 0, checks = 0, cycles = 0;
  bit finished = 0;

  // bench model
  logic [7:0] mSrV, mSrNv, mCrNv, mCrVol;
  logic mWel, mWip, mPErr, mEErr, mFrz, mOtp;
  int mOp; // 0 idle, 1 program, 2 erase, 3 fault

  sfRegCtrl #(.Sr1NvInit(SrInit), .Cr1NvInit(CrInit)) i_sfRegCtrl (
    .clk(clk), .rstN(rstN), .cmdWren(cmdWren), .cmdWrr(cmdWrr), .wrrTwoBytes(wrrTwoBytes),
    .wrrVolatile(wrrVolatile), .wrrByte0(wrrByte0), .wrrByte1(wrrByte1), .cmdClsr(cmdClsr),
    .cmdProg(cmdProg), .cmdErase(cmdErase), .opDone(opDone), .opFail(opFail),
    .opProtected(opProtected), .cmdOtpWr(cmdOtpWr), .sr1V(sr1V), .sr1Nv(sr1Nv),
    .cr1V(cr1V), .cr1Nv(cr1Nv), .busy(busy), .otpWrGo(otpWrGo)
  );

  always #5 clk = ~clk;

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", cycles);
      summary();
    end
  end

  function automatic logic [7:0] merge(input logic [7:0] oldV, input logic [7:0] newV, input logic [7:0] m);
    return (oldV & ~m) | (newV & m);
  endfunction

  function automatic logic [7:0] expSr1V();
    return (mSrV & 8'h9C) | {1'b0, mPErr, mEErr, 3'b000, mWel, mWip};
  endfunction

  function automatic logic [7:0] expCr1V();
    return (mCrVol & 8'hD2) | (mCrNv & 8'h2C) | {7'b0, mFrz};
  endfunction

  task automatic check(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic compareAll(input string tag);
    check(tag, "sr1V", sr1V, expSr1V());
    check(tag, "sr1Nv", sr1Nv, mSrNv);
    check(tag, "cr1V", cr1V, expCr1V());
    check(tag, "cr1Nv", cr1Nv, mCrNv);
    check(tag, "busy", {7'b0, busy}, {7'b0, mWip});
    check(tag, "otpWrGo", {7'b0, otpWrGo}, {7'b0, mOtp});
  endtask

  task automatic modelReset();
    mSrNv = SrInit & 8'h9C; mSrV = SrInit & 8'h9C;
    mCrNv = CrInit & 8'hFE; mCrVol = CrInit & 8'hD2;
    mWel = 0; mWip = 0; mPErr = 0; mEErr = 0; mFrz = 0; mOtp = 0; mOp = 0;
  endtask

  task automatic doReset();
    rstN = 1'b0;
    @(negedge clk); @(negedge clk);
    modelReset();
    rstN = 1'b1;
    compareAll("R1");
  endtask

  task automatic modelStep(input int cmd, input logic [7:0] b0, input logic [7:0] b1,
                           input logic two, input logic vol, input logic bad);
    logic [7:0] sm, cm;
    mOtp = 0;
    if (mOp == 0) begin
      if (cmd == CWrr && mWel) begin
        sm = mFrz ? 8'h80 : 8'h9C;
        cm = mFrz ? 8'hD2 : 8'hFE;
        mSrV = merge(mSrV, b0, sm);
        if (!vol) mSrNv = merge(mSrNv, b0, sm);
        if (two) begin
          mCrVol = merge(mCrVol, b1, 8'hD2);
          mFrz = mFrz | b1[0];
          if (!vol) mCrNv = merge(mCrNv, b1, cm);
        end
        mWel = 0;
      end else if ((cmd == CProg || cmd == CErase) && mWel) begin
        mWip = 1; mWel = 0; mOp = (cmd == CProg) ? 1 : 2;
      end else if (cmd == COtp && mWel && !mFrz) begin
        mOtp = 1; mWel = 0;
      end else if (cmd == CWren) begin
        mWel = 1;
      end
    end else if (mOp == 1 || mOp == 2) begin
      if (cmd == CDone) begin
        if (bad) begin
          if (mOp == 1) mPErr = 1; else mEErr = 1;
          mOp = 3;
        end else begin
          mWip = 0; mOp = 0;
        end
      end
    end else if (cmd == CClsr) begin
      mPErr = 0; mEErr = 0; mWip = 0; mWel = 0; mOp = 0;
    end
  endtask

  task automatic step(input string tag, input int cmd, input logic [7:0] b0 = 8'h00,
                      input logic [7:0] b1 = 8'h00, input logic two = 0, input logic vol = 0,
                      input logic fail = 0, input logic prot = 0);
    cmdWren = (cmd == CWren); cmdWrr = (cmd == CWrr); cmdProg = (cmd == CProg);
    cmdErase = (cmd == CErase); opDone = (cmd == CDone); cmdClsr = (cmd == CClsr);
    cmdOtpWr = (cmd == COtp);
    wrrByte0 = b0; wrrByte1 = b1; wrrTwoBytes = two; wrrVolatile = vol;
    opFail = fail; opProtected = prot;
    @(posedge clk);
    modelStep(cmd, b0, b1, two, vol, fail | prot);
    @(negedge clk);
    cmdWren = 0; cmdWrr = 0; cmdProg = 0; cmdErase = 0; opDone = 0; cmdClsr = 0; cmdOtpWr = 0;
    compareAll(tag);
  endtask

  initial begin
    void'($urandom(32'd4242));
    @(negedge clk);
    doReset();
    // R8 register write without the latch is ignored
    step("R8", CWrr, 8'hFF, 8'hFF, 1, 0);
    // R2 latch set
    step("R2", CWren);
    // R9 single byte leaves configuration alone
    step("R9", CWrr, 8'h94, 8'hFF, 0, 0);
    // R10 two-byte volatile write
    step("R2", CWren);
    step("R10", CWrr, 8'h08, 8'hF2, 1, 1);
    // R10 two-byte non-volatile write
    step("R2", CWren);
    step("R10", CWrr, 8'h1C, 8'h7E, 1, 0);
    // R3 start without latch has no effect, then real start
    step("R3", CProg);
    step("R2", CWren);
    step("R3", CProg);
    step("R2", CWren);            // ignored while busy
    step("R4", CDone);
    // R5 program failure stays latched
    step("R2", CWren);
    step("R3", CProg);
    step("R5", CDone, 0, 0, 0, 0, 1, 0);
    step("R5", CWren);
    step("R8", CWrr, 8'h00, 8'h00, 1, 0);
    step("R7", CClsr);
    // R6 erase to protected sector
    step("R2", CWren);
    step("R3", CErase);
    step("R7", CClsr);            // ignored while running clean
    step("R6", CDone, 0, 0, 0, 0, 0, 1);
    step("R6", CNone);
    step("R7", CClsr);
    // R13 OTP grant
    step("R2", CWren);
    step("R13", COtp);
    step("R13", COtp);            // no latch, no pulse
    // R12 set freeze, R11 locked fields
    step("R2", CWren);
    step("R12", CWrr, 8'h80, 8'h01, 1, 1);
    step("R2", CWren);
    step("R11", CWrr, 8'h00, 8'hFE, 1, 0);
    step("R2", CWren);
    step("R11", CWrr, 8'h9C, 8'h00, 1, 1);
    step("R2", CWren);
    step("R13", COtp);            // blocked by freeze
    step("R12", CWren);
    step("R12", CWrr, 8'h00, 8'h00, 1, 0); // freeze stays
    doReset();                    // R1 clears freeze
    for (int i = 0; i < 800; i++) begin
      int r;
      logic [7:0] a, b;
      r = $urandom % 11;
      a = 8'($urandom); b = 8'($urandom);
      case (r)
        0, 1: step("R2", CWren);
        2, 3: step("R10", CWrr, a, b, 1'($urandom), 1'($urandom));
        4:    step("R3", CProg);
        5:    step("R3", CErase);
        6, 7: step("R5", CDone, 0, 0, 0, 0, ($urandom % 4) == 0, ($urandom % 5) == 0);
        8:    step("R7", CClsr);
        9:    step("R13", COtp);
        default: step("R9", CWrr, a, b, 0, 1'($urandom));
      endcase
    end
    summary();
  end
endmodule